// File: doc/BRIEF.md
# Sequential Non-Restoring Unsigned Divider

This block divides one unsigned N-bit operand by another over several clock cycles and returns an N-bit quotient and an N-bit remainder. A caller presents both operands with a one-cycle `start` pulse while the unit is idle. `busy` stays high while the iterations run, and `done` pulses for one cycle when the result registers have been updated.

The datapath keeps a partial remainder that is one bit wider than the operands, plus a register that starts with the dividend and ends with the quotient. Each cycle it shifts the pair left by one bit. It then adds the divisor to the partial remainder if that value was negative before the shift, and subtracts it otherwise. The new quotient bit is the inverse of the resulting sign. No step undoes its own subtraction. The remainder is fixed only at the end, by one extra addition of the divisor, and only when the last partial remainder is negative.

A zero divisor skips the iterations. The unit then reports the condition on a flag, returns an all-ones quotient, and passes the dividend through as the remainder.

Top module: `nr_divider`

## Requirements
- R1: After reset, `busy`, `done` and `div_by_zero` are low, and `quotient` and `remainder` are zero.
- R2: For a start with a nonzero divisor, the result at `done` has `quotient` equal to floor(dividend/divisor) and `remainder` equal to dividend mod divisor.
- R3: Count the clock edge that samples `start` as edge 1. `done` is visible after edge N+1 when the quotient is odd (no correction is needed) and after edge N+2 when it is even (one correction cycle). `busy` is high from edge 1 until the edge that raises `done`, where it falls.
- R4: `done` is high for exactly one cycle per accepted start.
- R5: With a nonzero divisor, the reported remainder is always less than the divisor.
- R6: For a zero divisor, `done` is visible after edge 1 with `div_by_zero` high, `quotient` all ones, `remainder` equal to the dividend, and `busy` never high.
- R7: A later start with a nonzero divisor clears `div_by_zero` when it is accepted.
- R8: A `start` pulse while `busy` is high is ignored. The running division completes with its own operands and its own latency.
- R9: While idle with `start` low, `quotient`, `remainder` and `div_by_zero` hold their values, even if the operand inputs change.
- R10: The corner operands are correct: a dividend smaller than the divisor gives quotient 0 and the dividend as remainder, equal operands give 1 remainder 0, and the largest dividend divided by 1 gives itself with remainder 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a division; sampled only while idle |
| dividend | input | WIDTH | Unsigned dividend, sampled with start |
| divisor | input | WIDTH | Unsigned divisor, sampled with start |
| busy | output | 1 | Iterations or correction in progress |
| done | output | 1 | One-cycle pulse: result registers updated |
| div_by_zero | output | 1 | Last accepted divisor was zero |
| quotient | output | WIDTH | Registered quotient |
| remainder | output | WIDTH | Registered remainder |

## Verification
The latency of each result depends on the data. A zero divisor finishes one edge after `start` is sampled. A nonzero divisor finishes after N+1 edges when the expected quotient is odd and after N+2 edges when it is even, because an even quotient means the last partial remainder was negative and needs the correction cycle. The bench derives the due cycle from its own quotient for every case. It drives inputs and samples outputs on falling edges. It counts falling edges from the sampling edge and requires `done` to appear on exactly the predicted one and to be low on the next. Hold and ignore checks sample the outputs over idle and busy windows. The bench changes the operand inputs and raises a stray `start` inside those windows.

// File: rtl/nr_div_pkg.sv
package nr_div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ITER = 2'd1,
    ST_FIX  = 2'd2
  } div_state_e;
endpackage

// File: rtl/nr_div_step.sv
// One non-restoring iteration plus the final remainder correction, purely combinational.
module nr_div_step #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH:0]   part_i,
  input  logic [WIDTH-1:0] quo_i,
  input  logic [WIDTH-1:0] dvsr_i,
  output logic [WIDTH:0]   part_o,
  output logic [WIDTH-1:0] quo_o,
  output logic [WIDTH-1:0] rem_fix_o
);
  logic [WIDTH:0] shifted;
  logic [WIDTH:0] dvsr_ext;
  logic [WIDTH:0] sum;
  logic [WIDTH:0] fixed;

  always_comb begin
    dvsr_ext  = {1'b0, dvsr_i};
    shifted   = {part_i[WIDTH-1:0], quo_i[WIDTH-1]};
    // sign of the value before the shift picks add or subtract
    sum       = part_i[WIDTH] ? (shifted + dvsr_ext) : (shifted - dvsr_ext);
    part_o    = sum;
    quo_o     = {quo_i[WIDTH-2:0], ~sum[WIDTH]};
    fixed     = part_i + dvsr_ext;
    rem_fix_o = fixed[WIDTH-1:0];
  end
endmodule

// File: rtl/nr_div_ctrl.sv
// Sequencer: idle / iterate / correct, with the iteration counter.
module nr_div_ctrl
  import nr_div_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic zero_dvsr_i,
  input  logic next_neg_i,
  output logic load_o,
  output logic zero_fin_o,
  output logic step_o,
  output logic plain_fin_o,
  output logic fix_fin_o,
  output logic busy_o
);
  localparam int CW = $clog2(WIDTH + 1);

  div_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          last_step;

  always_comb begin
    load_o      = (state_q == ST_IDLE) && start_i && !zero_dvsr_i;
    zero_fin_o  = (state_q == ST_IDLE) && start_i && zero_dvsr_i;
    step_o      = (state_q == ST_ITER);
    last_step   = step_o && (cnt_q == CW'(1));
    plain_fin_o = last_step && !next_neg_i;
    fix_fin_o   = (state_q == ST_FIX);
    busy_o      = (state_q != ST_IDLE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (load_o) begin
          state_q <= ST_ITER;
          cnt_q   <= CW'(WIDTH);
        end
        ST_ITER: begin
          cnt_q <= cnt_q - CW'(1);
          if (last_step) state_q <= next_neg_i ? ST_FIX : ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3: an iteration is never performed with an exhausted counter
  a_r3_cnt_live: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ITER) |-> (cnt_q != '0));
  // R3: the correction cycle is always followed by idle
  a_r3_fix_once: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FIX) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/nr_divider.sv
module nr_divider
  import nr_div_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic             div_by_zero,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);
  logic [WIDTH:0]   part_q;
  logic [WIDTH-1:0] quo_q;
  logic [WIDTH-1:0] dvsr_q;
  logic [WIDTH:0]   part_nxt;
  logic [WIDTH-1:0] quo_nxt;
  logic [WIDTH-1:0] rem_fix;
  logic             load, zero_fin, step, plain_fin, fix_fin;

  nr_div_step #(.WIDTH(WIDTH)) u_step (
    .part_i   (part_q),
    .quo_i    (quo_q),
    .dvsr_i   (dvsr_q),
    .part_o   (part_nxt),
    .quo_o    (quo_nxt),
    .rem_fix_o(rem_fix)
  );

  nr_div_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start),
    .zero_dvsr_i(divisor == '0),
    .next_neg_i (part_nxt[WIDTH]),
    .load_o     (load),
    .zero_fin_o (zero_fin),
    .step_o     (step),
    .plain_fin_o(plain_fin),
    .fix_fin_o  (fix_fin),
    .busy_o     (busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      part_q      <= '0;
      quo_q       <= '0;
      dvsr_q      <= '0;
      quotient    <= '0;
      remainder   <= '0;
      done        <= 1'b0;
      div_by_zero <= 1'b0;
    end else begin
      done <= zero_fin | plain_fin | fix_fin;
      if (load) begin
        part_q      <= '0;
        quo_q       <= dividend;
        dvsr_q      <= divisor;
        div_by_zero <= 1'b0;
      end else if (step) begin
        part_q <= part_nxt;
        quo_q  <= quo_nxt;
      end
      if (zero_fin) begin
        quotient    <= '1;
        remainder   <= dividend;
        div_by_zero <= 1'b1;
      end else if (plain_fin) begin
        quotient  <= quo_nxt;
        remainder <= part_nxt[WIDTH-1:0];
      end else if (fix_fin) begin
        quotient  <= quo_q;
        remainder <= rem_fix;
      end
    end
  end

  a_r4_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r3_busy_ends_with_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  a_r5_rem_below: assert property (@(posedge clk) disable iff (rst)
    (done && !div_by_zero) |-> (remainder < dvsr_q));
  a_r6_zero_result: assert property (@(posedge clk) disable iff (rst)
    (done && div_by_zero) |-> (quotient == '1 && !busy));
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero)));
  a_r8_ignore_start: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(dvsr_q));
endmodule

// File: tb/sim_nr_divider.sv
module sim_nr_divider;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy, done, div_by_zero;
  logic [W-1:0] quotient, remainder;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  nr_divider #(.WIDTH(W)) u0 (
    .clk(clk), .rst(rst), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .div_by_zero(div_by_zero),
    .quotient(quotient), .remainder(remainder)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Runs one division; optional stray start at falling edge 'stray_at' (0 = none).
  task automatic run_div(input string req, input int a, input int b, input int stray_at);
    int exp_q, exp_r, lat, seen;
    if (b == 0) begin exp_q = (1 << W) - 1; exp_r = a; lat = 1; end
    else begin
      exp_q = a / b; exp_r = a % b;
      lat = (exp_q % 2 == 1) ? W + 1 : W + 2;
    end
    @(negedge clk);
    start = 1'b1; dividend = W'(a); divisor = W'(b);
    @(posedge clk);
    seen = 0;
    for (int k = 1; k <= W + 4 && seen == 0; k++) begin
      @(negedge clk);
      start = 1'b0;
      if (k == stray_at) begin start = 1'b1; dividend = 8'd50; divisor = 8'd0; end
      else begin dividend = ~dividend; divisor = 8'd3; end
      if (k == 1) check({req, " R3 busy after start"}, busy, (b != 0) ? 1 : 0);
      if (done) seen = k;
    end
    start = 1'b0;
    check({req, " R3 latency"}, seen, lat);
    check({req, " R2 quotient"}, quotient, exp_q);
    check({req, " R2 remainder"}, remainder, exp_r);
    check({req, " R6 flag"}, div_by_zero, (b == 0) ? 1 : 0);
    check({req, " R3 busy low at done"}, busy, 0);
    if (b != 0) check({req, " R5 rem below divisor"}, (remainder < b) ? 1 : 0, 1);
    @(negedge clk);
    check({req, " R4 done one cycle"}, done, 0);
  endtask

  task automatic t_reset();
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 flag", div_by_zero, 0);
    check("R1 quotient", quotient, 0);
    check("R1 remainder", remainder, 0);
  endtask

  task automatic t_basic();
    run_div("R2 14/3", 14, 3, 0);
    run_div("R2 200/7", 200, 7, 0);
    run_div("R2 255/16", 255, 16, 0);
    run_div("R2 99/9", 99, 9, 0);
    run_div("R2 173/254", 173, 254, 0);
  endtask

  task automatic t_corners();
    run_div("R10 small dividend", 5, 200, 0);
    run_div("R10 equal", 131, 131, 0);
    run_div("R10 max by one", 255, 1, 0);
    run_div("R10 zero dividend", 0, 17, 0);
    run_div("R10 max by max", 255, 255, 0);
  endtask

  task automatic t_zero();
    run_div("R6 zero divisor", 77, 0, 0);
    run_div("R7 clear flag", 60, 8, 0);
  endtask

  task automatic t_ignore();
    run_div("R8 stray start", 200, 7, 4);
  endtask

  task automatic t_hold();
    int q0, r0;
    run_div("R9 setup", 123, 10, 0);
    q0 = quotient; r0 = remainder;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      dividend = W'(i * 37); divisor = W'(i);
    end
    check("R9 quotient held", quotient, q0);
    check("R9 remainder held", remainder, r0);
    check("R9 flag held", div_by_zero, 0);
    check("R9 busy idle", busy, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_corners();
    t_zero();
    t_ignore();
    t_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule